// File: doc/BRIEF.md
# FIFO-Ordered Set-Associative Tag Lookup

This block holds the tags and valid bits of a word-addressed data cache, 4-way set-associative, with 4K entries in total and one 64-bit word per block. A requester may present one 30-bit word address per cycle. The low 10 bits select one of 1024 sets and the upper 20 bits form the tag. All four ways of the selected set are compared at once. The result comes back as a registered hit or miss strobe on the following cycle.

Replacement is first-in first-out, and the order is kept physically. On a miss, the new tag is written into way 0, each older entry moves one way to the right, and whatever was in way 3 is dropped. A hit never changes the order. Because of this, way 0 always holds the newest entry of its set and way 3 the oldest. There is no pointer and no age state. Two saturating counters record the hits and misses. A combinational debug port returns the tags and valid bits of any set, in way order. Data storage, writes and the backing memory belong to other blocks.

Top module: `fifo_tag_lookup`

## Requirements
- R1: A request address splits into set index `req_addr[9:0]` and tag `req_addr[29:10]`. Only the indexed set is looked up or changed.
- R2: Every request (`req_valid` high at a clock edge) gives exactly one of `rsp_hit` or `rsp_miss` high for the one cycle after that edge. Both are low after an edge with no request.
- R3: The result is a hit exactly when some valid way of the indexed set holds the request tag. All ways are compared in parallel, and at most one way can match.
- R4: A hit leaves the tags, valid bits and way order of every set unchanged.
- R5: A miss writes the new tag with its valid bit set into way 0 and moves the contents of way k to way k+1 for k = 0..2. The old way 3 entry is discarded.
- R6: A miss into a set that is not full still shifts. The new entry goes into way 0, and empty slots are not searched for.
- R7: A synchronous active-high `rst` clears every valid bit, both counters and both response strobes. Every lookup after reset misses until its tag is installed.
- R8: `hit_count` and `miss_count` each increase by one at the same edge that registers a hit or a miss. Each one holds at its all-ones value once it gets there.
- R9: `dbg_tags` combinationally returns the set selected by `dbg_set`, with way w in bits [20w+19:20w]. `dbg_valid[w]` is the valid bit of way w. Both show the state after the most recent clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_addr | input | 30 | Word address of the lookup |
| rsp_hit | output | 1 | Previous-cycle request hit |
| rsp_miss | output | 1 | Previous-cycle request missed and was installed |
| hit_count | output | CNT_W (32) | Saturating hit total |
| miss_count | output | CNT_W (32) | Saturating miss total |
| dbg_set | input | 10 | Set chosen for the debug read |
| dbg_tags | output | 80 | Tags of the chosen set, way 0 in the low bits |
| dbg_valid | output | 4 | Valid bits of the chosen set, bit w for way w |

## Verification
The assertions check on every cycle that exactly one response strobe answers each request and none answers an idle cycle. They also check that no two ways of a set ever match one tag, that each hit advances the hit count by one, and that a saturated count stays put. The physical FIFO order cannot be seen from those local relations: way-0 insertion, the right shift with eviction from way 3, order kept on hits, shifting into partly filled sets, and everything missing after reset. Only the bench's scenarios show these, by comparing the debug port and the strobes against a reference model after each request.

// File: rtl/ctag_pkg.sv
package ctag_pkg;
   typedef enum logic [1:0] {
      RESP_IDLE = 2'd0,
      RESP_HIT  = 2'd1,
      RESP_MISS = 2'd2
   } resp_e;
endpackage

// File: rtl/ctag_compare.sv
module ctag_compare #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 20
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0]            valid,
   input  logic [TAG_W-1:0]           tag,
   output logic [WAYS-1:0]            way_hit,
   output logic                       any_hit
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_hit[w] = valid[w] && (tags[w] == tag);
   end
   assign any_hit = |way_hit;
endmodule

// File: rtl/ctag_set_store.sv
module ctag_set_store #(
   parameter int IDX_W = 10,
   parameter int WAYS  = 4,
   parameter int TAG_W = 20
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [IDX_W-1:0]           rd_idx,
   output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
   output logic [WAYS-1:0]            rd_valid,
   input  logic [IDX_W-1:0]           dbg_idx,
   output logic [WAYS-1:0][TAG_W-1:0] dbg_tags,
   output logic [WAYS-1:0]            dbg_valid,
   input  logic                       fill_en,
   input  logic [IDX_W-1:0]           fill_idx,
   input  logic [TAG_W-1:0]           fill_tag
);
   localparam int SETS = 1 << IDX_W;

   logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
   logic [WAYS-1:0]            val_mem [SETS];

   assign rd_tags   = tag_mem[rd_idx];
   assign rd_valid  = val_mem[rd_idx];
   assign dbg_tags  = tag_mem[dbg_idx];
   assign dbg_valid = val_mem[dbg_idx];

   if (WAYS > 1) begin : g_shift
      always_ff @(posedge clk) begin
         if (fill_en)
            tag_mem[fill_idx] <= {tag_mem[fill_idx][WAYS-2:0], fill_tag};
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < SETS; s++) val_mem[s] <= '0;
         end else if (fill_en) begin
            val_mem[fill_idx] <= {val_mem[fill_idx][WAYS-2:0], 1'b1};
         end
      end
   end else begin : g_single
      always_ff @(posedge clk) begin
         if (fill_en) tag_mem[fill_idx] <= fill_tag;
      end
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int s = 0; s < SETS; s++) val_mem[s] <= '0;
         end else if (fill_en) begin
            val_mem[fill_idx] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ctag_sat_counter.sv
module ctag_sat_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst)                         count <= '0;
      else if (inc && count != CNT_MAX) count <= count + 1'b1;
   end
endmodule

// File: rtl/fifo_tag_lookup.sv
module fifo_tag_lookup
   import ctag_pkg::*;
#(
   parameter int ADDR_W = 30,
   parameter int IDX_W  = 10,
   parameter int WAYS   = 4,
   parameter int CNT_W  = 32
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            req_valid,
   input  logic [ADDR_W-1:0]               req_addr,
   output logic                            rsp_hit,
   output logic                            rsp_miss,
   output logic [CNT_W-1:0]                hit_count,
   output logic [CNT_W-1:0]                miss_count,
   input  logic [IDX_W-1:0]                dbg_set,
   output logic [WAYS*(ADDR_W-IDX_W)-1:0]  dbg_tags,
   output logic [WAYS-1:0]                 dbg_valid
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("fifo_tag_lookup: ADDR_W must exceed IDX_W");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("fifo_tag_lookup: WAYS must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("fifo_tag_lookup: CNT_W must be at least 1");
   end

   logic [IDX_W-1:0]           req_idx;
   logic [TAG_W-1:0]           req_tag;
   logic [WAYS-1:0][TAG_W-1:0] set_tags;
   logic [WAYS-1:0]            set_valid;
   logic [WAYS-1:0][TAG_W-1:0] dbg_tags_w;
   logic [WAYS-1:0]            way_hit;
   logic                       any_hit;
   logic                       fill_en;
   resp_e                      resp_q;

   assign req_idx = req_addr[IDX_W-1:0];
   assign req_tag = req_addr[ADDR_W-1:IDX_W];
   assign fill_en = req_valid && !any_hit;

   ctag_set_store #(.IDX_W(IDX_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
      .clk       (clk),
      .rst       (rst),
      .rd_idx    (req_idx),
      .rd_tags   (set_tags),
      .rd_valid  (set_valid),
      .dbg_idx   (dbg_set),
      .dbg_tags  (dbg_tags_w),
      .dbg_valid (dbg_valid),
      .fill_en   (fill_en),
      .fill_idx  (req_idx),
      .fill_tag  (req_tag)
   );

   ctag_compare #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
      .tags    (set_tags),
      .valid   (set_valid),
      .tag     (req_tag),
      .way_hit (way_hit),
      .any_hit (any_hit)
   );

   ctag_sat_counter #(.CNT_W(CNT_W)) u_hits (
      .clk   (clk),
      .rst   (rst),
      .inc   (req_valid && any_hit),
      .count (hit_count)
   );

   ctag_sat_counter #(.CNT_W(CNT_W)) u_misses (
      .clk   (clk),
      .rst   (rst),
      .inc   (fill_en),
      .count (miss_count)
   );

   always_ff @(posedge clk) begin
      if (rst)            resp_q <= RESP_IDLE;
      else if (!req_valid) resp_q <= RESP_IDLE;
      else if (any_hit)   resp_q <= RESP_HIT;
      else                resp_q <= RESP_MISS;
   end

   assign rsp_hit  = (resp_q == RESP_HIT);
   assign rsp_miss = (resp_q == RESP_MISS);
   assign dbg_tags = dbg_tags_w;
endmodule

// File: rtl/ctag_checker.sv
module ctag_checker #(
   parameter int WAYS  = 4,
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             req_valid,
   input logic             rsp_hit,
   input logic             rsp_miss,
   input logic [CNT_W-1:0] hit_count,
   input logic [WAYS-1:0]  way_hit
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
      !(rsp_hit && rsp_miss)); // R2

   AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> (rsp_hit || rsp_miss)); // R2

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!rsp_hit && !rsp_miss)); // R2

   AST_UNIQUE_WAY: assert property (@(posedge clk) disable iff (rst)
      $onehot0(way_hit)); // R3

   AST_HIT_STEP: assert property (@(posedge clk) disable iff (rst)
      (rsp_hit && $past(hit_count) != CNT_MAX) |->
         hit_count == CNT_W'($past(hit_count) + 1'b1)); // R8

   AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (hit_count == CNT_MAX) |=> (hit_count == CNT_MAX)); // R8
endmodule

bind fifo_tag_lookup ctag_checker #(.WAYS(WAYS), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .rsp_hit   (rsp_hit),
   .rsp_miss  (rsp_miss),
   .hit_count (hit_count),
   .way_hit   (way_hit)
);

// File: tb/sim_fifo_tag_lookup.sv
`timescale 1ns/1ps
module sim_fifo_tag_lookup;
   localparam int ADDR_W = 30;
   localparam int IDX_W  = 10;
   localparam int WAYS   = 4;
   localparam int CNT_W  = 8;
   localparam int TAG_W  = ADDR_W - IDX_W;
   localparam int SETS   = 1 << IDX_W;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic                    clk = 0;
   logic                    rst = 1;
   logic                    req_valid = 0;
   logic [ADDR_W-1:0]       req_addr = '0;
   logic                    rsp_hit, rsp_miss;
   logic [CNT_W-1:0]        hit_count, miss_count;
   logic [IDX_W-1:0]        dbg_set = '0;
   logic [WAYS*TAG_W-1:0]   dbg_tags;
   logic [WAYS-1:0]         dbg_valid;

   always #2.5 clk = ~clk;

   fifo_tag_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAYS(WAYS), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .hit_count(hit_count), .miss_count(miss_count),
      .dbg_set(dbg_set), .dbg_tags(dbg_tags), .dbg_valid(dbg_valid)
   );

   logic [TAG_W-1:0] m_tag [SETS][WAYS];
   logic             m_val [SETS][WAYS];
   int exp_hits, exp_misses;
   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit ref_hit(input logic [ADDR_W-1:0] a);
      bit h = 0;
      for (int w = 0; w < WAYS; w++)
         if (m_val[a[IDX_W-1:0]][w] && m_tag[a[IDX_W-1:0]][w] == a[ADDR_W-1:IDX_W]) h = 1;
      return h;
   endfunction

   task automatic ref_clear();
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) begin
            m_val[s][w] = 0;
            m_tag[s][w] = '0;
         end
      exp_hits = 0;
      exp_misses = 0;
   endtask

   task automatic chk_set(input logic [IDX_W-1:0] s, input string req);
      logic [WAYS*TAG_W-1:0] e = '0, a = '0;
      logic [WAYS-1:0] ev;
      dbg_set = s;
      #0.1;
      for (int w = 0; w < WAYS; w++) begin
         ev[w] = m_val[s][w];
         if (m_val[s][w]) begin
            e[w*TAG_W +: TAG_W] = m_tag[s][w];
            a[w*TAG_W +: TAG_W] = dbg_tags[w*TAG_W +: TAG_W];
         end
      end
      chk(dbg_valid == ev, {req, " valid bits"}, 128'(dbg_valid), 128'(ev));
      chk(a == e, {req, " tag order"}, 128'(a), 128'(e));
   endtask

   // Called at a negedge; one request per cycle, checked at the next negedge.
   task automatic step(input bit v, input logic [ADDR_W-1:0] a, input string req);
      bit h;
      logic [IDX_W-1:0] s = a[IDX_W-1:0];
      h = v && ref_hit(a);
      if (v && h) exp_hits = (exp_hits < CMAX) ? exp_hits + 1 : CMAX;
      if (v && !h) begin
         exp_misses = (exp_misses < CMAX) ? exp_misses + 1 : CMAX;
         for (int w = WAYS - 1; w > 0; w--) begin
            m_tag[s][w] = m_tag[s][w-1];
            m_val[s][w] = m_val[s][w-1];
         end
         m_tag[s][0] = a[ADDR_W-1:IDX_W];
         m_val[s][0] = 1;
      end
      req_valid = v;
      req_addr  = a;
      @(posedge clk);
      @(negedge clk);
      chk(rsp_hit == h, "R3 hit strobe", 128'(rsp_hit), 128'(h));
      chk(rsp_miss == (v && !h), "R2 miss strobe", 128'(rsp_miss), 128'(v && !h));
      chk(hit_count == CNT_W'(exp_hits), "R8 hit count", 128'(hit_count), 128'(exp_hits));
      chk(miss_count == CNT_W'(exp_misses), "R8 miss count", 128'(miss_count), 128'(exp_misses));
      if (v) chk_set(s, req);
   endtask

   function automatic logic [ADDR_W-1:0] mk(input int tag, input int set);
      return {TAG_W'(tag), IDX_W'(set)};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1;
      req_valid = 0;
      ref_clear();
      repeat (2) @(negedge clk);
      rst = 0;
   endtask

   initial begin
      ref_clear();
      do_reset();
      // R7: reset state
      chk(!rsp_hit && !rsp_miss, "R7 strobes after reset", 128'({rsp_hit, rsp_miss}), 128'(0));
      chk(hit_count == 0 && miss_count == 0, "R7 counters after reset",
          128'({hit_count, miss_count}), 128'(0));
      chk_set(10'd0, "R7 set 0 cold");
      chk_set(10'd1023, "R7 set 1023 cold");

      // R1: the index comes from the low bits; a neighbour set is untouched
      step(1, mk(20'hABCDE, 5), "R1 install");
      chk_set(10'd6, "R1 neighbour set");
      chk_set(10'd4, "R1 other neighbour");

      // R6: second miss into a partly filled set shifts
      step(1, mk(20'h00011, 5), "R6 partial shift");
      step(1, mk(20'h00022, 5), "R6 partial shift 2");

      // R5: fill and overflow, oldest leaves from way 3
      step(1, mk(20'h00033, 5), "R5 full set");
      step(1, mk(20'h00044, 5), "R5 evict");
      step(1, mk(20'hABCDE, 5), "R5 evicted tag misses");

      // R4: hits on the oldest and newest keep the order
      step(1, mk(20'h00022, 5), "R4 hit oldest");
      step(1, mk(20'hABCDE, 5), "R4 hit newest");

      // R2: idle cycle answers nothing
      step(0, '0, "R2 idle");
      step(0, '0, "R2 idle 2");

      // R9: debug port shows another set without disturbing the lookup path
      chk_set(10'd5, "R9 debug readback");

      // Random traffic: few sets and tags for a rich hit/miss mix, saturates R8
      begin
         int seed_dummy;
         seed_dummy = $urandom(32'h5EED_0042);
      end
      for (int i = 0; i < 3000; i++) begin
         int r = int'($urandom_range(0, 99));
         int t = int'($urandom_range(0, 5));
         int s = (r < 80) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, SETS - 1));
         step(r >= 8, mk(t, s), "R5 random");
      end
      chk(hit_count == CNT_W'(CMAX), "R8 hit count saturated", 128'(hit_count), 128'(CMAX));

      // R7: reset in the middle of traffic, everything misses again
      do_reset();
      chk_set(10'd5, "R7 set 5 cleared");
      step(1, mk(20'h00022, 5), "R7 miss after reset");
      step(1, mk(20'h00022, 5), "R3 hit after reinstall");

      @(negedge clk);
      req_valid = 0;
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule